// File: doc/BRIEF.md
# Receive Destination Address Filter

This block watches the start of each received frame and decides, from the destination address alone, whether the frame is for this station. It takes one byte per cycle with a start marker and an end marker. It captures the first six bytes and keeps a running CRC over them. After the header it produces a registered verdict made of a miss flag and an accept flag.

Three address classes are told apart, with a fixed priority: broadcast, then group or hashed addresses, then exact unicast match. Broadcast can be switched off. A mode bit can route individual addresses through the hash table instead of the exact compare. A promiscuous mode lets every frame through but keeps the miss flag, so that later stages can still tag the frame as not addressed to the station.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, and whenever no verdict is held, `done_o`, `accept_o` and `miss_o` are all 0.
- R2: A destination of six 0xFF bytes is broadcast: it is a miss when `bcast_dis_i` is 1 and a hit when it is 0, whatever the other mode bits are.
- R3: A non-broadcast destination whose first byte has bit 0 set uses the hash. The CRC starts at all ones, with polynomial 0x04C11DB7, no final inversion, and each byte fed least significant bit first, MSB-shifting. The index is CRC bits [31:26]. Index 0..31 selects `hash_lo_i[idx]` and index 32..63 selects `hash_hi_i[idx-32]`. A clear bit means a miss.
- R4: With `all_ind_i` set, a non-broadcast destination whose first byte has bit 0 clear also uses the hash path of R3 rather than the exact compare.
- R5: Otherwise the destination is a hit only if byte 0 equals `sta_hi_i[15:8]`, byte 1 equals `sta_hi_i[7:0]`, and bytes 2..5 equal `sta_lo_i[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. Any differing byte is a miss.
- R6: `accept_o` equals NOT `miss_o` when `promisc_i` is 0. When `promisc_i` is 1, `accept_o` is 1 and `miss_o` still reports the miss.
- R7: A frame whose end marker arrives on byte 1 to 5 yields a verdict with `miss_o` = 1.
- R8: `done_o` rises one clock after the edge that samples the sixth byte, or the short frame's last byte. The verdict then holds, unaffected by inputs, until a start marker, which clears all three outputs at that edge.
- R9: Cycles with `valid_i` low are not counted as address bytes.
- R10: Bytes after the sixth do not change the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| valid_i | input | 1 | byte on `data_i` is valid |
| sof_i | input | 1 | first byte of a frame |
| eof_i | input | 1 | last byte of a frame |
| data_i | input | 8 | received byte |
| bcast_dis_i | input | 1 | treat broadcast as a miss |
| all_ind_i | input | 1 | send individual addresses through the hash |
| promisc_i | input | 1 | accept missed frames |
| sta_hi_i | input | 16 | station address bytes 0 and 1 |
| sta_lo_i | input | 32 | station address bytes 2 to 5 |
| hash_lo_i | input | 32 | hash bins 0 to 31 |
| hash_hi_i | input | 32 | hash bins 32 to 63 |
| done_o | output | 1 | verdict valid |
| accept_o | output | 1 | frame accepted |
| miss_o | output | 1 | frame not addressed to station |

## Verification
Every combination of the three mode bits is crossed with five kinds of destination. A broadcast tests the broadcast priority and its disable bit. An exact station match is one kind. Six single-byte mismatches, one for each byte position, catch any swapped byte lane in the compare. Sixteen group addresses, each run with only its own hash bin set and then with only that bin clear, cover the CRC, the index and the hi/lo register split. Short frames of one to five bytes prove the early-end path. One frame with idle gaps and trailing payload separates counting from timing, and a cycle-exact run pins the verdict latency, the hold and the clear on a new start marker.

// File: rtl/rx_da_pkg.sv
package rx_da_pkg;
  localparam int unsigned DA_BYTES = 6;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned IDX_W    = 6;
  localparam int unsigned CRC_W    = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  // one byte, lsb first, msb-shifting register
  function automatic logic [CRC_W-1:0] crc_step8(input logic [CRC_W-1:0] c,
                                                 input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[CRC_W-1] ^ d[i]) r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                   r = {r[CRC_W-2:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/rx_da_capture.sv
module rx_da_capture #(
  parameter int unsigned NBYTES = 6,
  parameter int unsigned BW     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               sof_i,
  input  logic               eof_i,
  input  logic [BW-1:0]      data_i,
  output logic               take_o,
  output logic               first_o,
  output logic [NBYTES*BW-1:0] dest_o,
  output logic               full_o,
  output logic               short_o
);
  localparam int unsigned DW    = NBYTES * BW;
  localparam int unsigned CNT_W = $clog2(NBYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             open_q;
  logic [DW-1:0]    dest_q;
  logic             full_q, short_q;

  assign first_o = valid_i & sof_i;
  assign take_o  = valid_i & (sof_i | open_q);
  assign cnt_nxt = sof_i ? CNT_W'(1) : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      open_q  <= 1'b0;
      dest_q  <= '0;
      full_q  <= 1'b0;
      short_q <= 1'b0;
    end else begin
      full_q  <= take_o && (cnt_nxt == LAST);
      short_q <= take_o && eof_i && (cnt_nxt < LAST);
      if (take_o) begin
        cnt_q  <= cnt_nxt;
        dest_q <= {dest_q[DW-BW-1:0], data_i};
        open_q <= !eof_i && (cnt_nxt < LAST);
      end
    end
  end

  assign dest_o  = dest_q;
  assign full_o  = full_q;
  assign short_o = short_q;
endmodule

// File: rtl/rx_da_crc.sv
module rx_da_crc #(
  parameter int unsigned IW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          first_i,
  input  logic [7:0]    data_i,
  output logic [IW-1:0] idx_o
);
  import rx_da_pkg::*;

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_SEED;
    else if (take_i) crc_q <= crc_step8(first_i ? CRC_SEED : crc_q, data_i);
  end

  assign idx_o = crc_q[CRC_W-1 -: IW];
endmodule

// File: rtl/rx_da_decide.sv
module rx_da_decide #(
  parameter int unsigned NBYTES = 6,
  parameter int unsigned BW     = 8,
  parameter int unsigned IW     = 6
) (
  input  logic [NBYTES*BW-1:0] dest_i,
  input  logic [NBYTES*BW-1:0] sta_i,
  input  logic [IW-1:0]        idx_i,
  input  logic [(1<<IW)-1:0]   hash_i,
  input  logic                 short_i,
  input  logic                 bcast_dis_i,
  input  logic                 all_ind_i,
  output logic                 miss_o
);
  localparam int unsigned DW = NBYTES * BW;

  logic group_bit;
  assign group_bit = dest_i[DW-BW];  // lsb of first byte

  always_comb begin
    if (short_i)                      miss_o = 1'b1;
    else if (&dest_i)                 miss_o = bcast_dis_i;
    else if (group_bit || all_ind_i)  miss_o = !hash_i[idx_i];
    else                              miss_o = (dest_i != sta_i);
  end
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rx_da_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic        sof_i,
  input  logic        eof_i,
  input  logic [7:0]  data_i,
  input  logic        bcast_dis_i,
  input  logic        all_ind_i,
  input  logic        promisc_i,
  input  logic [15:0] sta_hi_i,
  input  logic [31:0] sta_lo_i,
  input  logic [31:0] hash_lo_i,
  input  logic [31:0] hash_hi_i,
  output logic        done_o,
  output logic        accept_o,
  output logic        miss_o
);
  localparam int unsigned DW = DA_BYTES * BYTE_W;

  logic          take, first, full, short_f, miss_c;
  logic [DW-1:0] dest;
  logic [IDX_W-1:0] idx;
  logic done_q, acc_q, miss_q;

  rx_da_capture #(.NBYTES(DA_BYTES), .BW(BYTE_W)) u_cap (
    .clk_i, .rst_ni, .valid_i, .sof_i, .eof_i, .data_i,
    .take_o(take), .first_o(first), .dest_o(dest),
    .full_o(full), .short_o(short_f)
  );

  rx_da_crc #(.IW(IDX_W)) u_crc (
    .clk_i, .rst_ni, .take_i(take), .first_i(first), .data_i,
    .idx_o(idx)
  );

  rx_da_decide #(.NBYTES(DA_BYTES), .BW(BYTE_W), .IW(IDX_W)) u_dec (
    .dest_i(dest), .sta_i({sta_hi_i, sta_lo_i}), .idx_i(idx),
    .hash_i({hash_hi_i, hash_lo_i}), .short_i(short_f),
    .bcast_dis_i, .all_ind_i, .miss_o(miss_c)
  );

  // a verdict due this cycle wins over a new start marker
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      acc_q  <= 1'b0;
      miss_q <= 1'b0;
    end else if (full || short_f) begin
      done_q <= 1'b1;
      miss_q <= miss_c;
      acc_q  <= !miss_c || promisc_i;
    end else if (first) begin
      done_q <= 1'b0;
      acc_q  <= 1'b0;
      miss_q <= 1'b0;
    end
  end

  assign done_o   = done_q;
  assign accept_o = acc_q;
  assign miss_o   = miss_q;
endmodule

// File: rtl/rx_da_filter_chk.sv
module rx_da_filter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic sof_i,
  input logic promisc_i,
  input logic done_o,
  input logic accept_o,
  input logic miss_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!accept_o && !miss_o));

  p_verdict_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(valid_i && sof_i)) |=> (done_o && $stable(accept_o) && $stable(miss_o)));

  p_sof_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && valid_i && sof_i) |=> !done_o);

  p_promisc_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && $past(promisc_i)) |-> accept_o);

  p_strict_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && !$past(promisc_i)) |-> (accept_o == !miss_o));
endmodule

bind rx_da_filter rx_da_filter_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sof_i(sof_i),
  .promisc_i(promisc_i), .done_o(done_o), .accept_o(accept_o), .miss_o(miss_o)
);

// File: tb/rx_da_filter_tb_top.sv
`timescale 1ns/1ps
module rx_da_filter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic valid = 0, sof = 0, eof = 0;
  logic [7:0] data = 0;
  logic bdis = 0, aind = 0, prom = 0;
  logic [47:0] sta = 48'h02_11_22_33_44_55;
  logic [63:0] hash = '0;
  logic done, acc, miss;

  rx_da_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sof_i(sof), .eof_i(eof),
    .data_i(data), .bcast_dis_i(bdis), .all_ind_i(aind), .promisc_i(prom),
    .sta_hi_i(sta[47:32]), .sta_lo_i(sta[31:0]),
    .hash_lo_i(hash[31:0]), .hash_hi_i(hash[63:32]),
    .done_o(done), .accept_o(acc), .miss_o(miss)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_idx(input logic [47:0] da);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 8; i++) begin
        logic fb = c[31] ^ da[40 - 8*b + i];
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    return c[31:26];
  endfunction

  function automatic logic ref_miss(input logic [47:0] da, input int nb);
    if (nb < 6) return 1'b1;
    if (da == 48'hFFFF_FFFF_FFFF) return bdis;
    if (da[40] || aind) return !hash[ref_idx(da)];
    return da != sta;
  endfunction

  task automatic send(input logic [47:0] da, input int nb, input int extra, input int gap);
    int n = (nb < 6) ? nb : 6 + extra;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1; sof = (i == 0); eof = (i == n - 1);
      data = (i < 6) ? da[47 - 8*i -: 8] : 8'(8'hA5 ^ i);
      if (gap > 0 && i != n - 1)
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          valid = 0; sof = 1; eof = 1; data = 8'h3C;
        end
    end
    @(negedge clk);
    valid = 0; sof = 0; eof = 0;
    @(negedge clk);
  endtask

  task automatic run_case(input string tag, input logic [47:0] da, input int nb,
                          input int extra, input int gap);
    logic em;
    em = ref_miss(da, nb);
    send(da, nb, extra, gap);
    chk({tag, " done R8"}, 32'(done), 32'd1);
    chk({tag, " miss"}, 32'(miss), 32'(em));
    chk({tag, " accept R6"}, 32'(acc), 32'(!em || prom));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("reset R1 done", 32'(done), 0);
    chk("reset R1 accept", 32'(acc), 0);
    chk("reset R1 miss", 32'(miss), 0);
    rst_n = 1;
    @(negedge clk);

    for (int m = 0; m < 8; m++) begin
      bdis = m[0]; aind = m[1]; prom = m[2];
      hash = '0;
      run_case("bcast R2", 48'hFFFF_FFFF_FFFF, 6, 0, 0);
      run_case("uni match R5 R4", sta, 6, 0, 0);
      hash = 64'd1 << ref_idx(sta);
      run_case("uni via hash R4", sta, 6, 0, 0);
      hash = '0;
      for (int p = 0; p < 6; p++)
        run_case("uni byte mismatch R5", sta ^ (48'h02 << (8*(5-p))), 6, 0, 0);
      for (int k = 0; k < 16; k++) begin
        logic [47:0] da = {8'(8'h01 | (k << 1)), 8'h00, 8'h5E, 8'(k*7), 8'h10, 8'(k)};
        hash = 64'd1 << ref_idx(da);
        run_case("mcast bin set R3", da, 6, 0, 0);
        hash = ~(64'd1 << ref_idx(da));
        run_case("mcast bin clear R3", da, 6, 0, 0);
      end
      hash = '0;
      for (int n = 1; n < 6; n++)
        run_case("short frame R7", sta, n, 0, 0);
    end

    bdis = 0; aind = 0; prom = 0; hash = '0;
    run_case("gaps R9 payload R10", sta, 6, 5, 2);

    // cycle-exact latency, hold and clear (R8)
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      valid = 1; sof = (i == 0); eof = 0; data = sta[47 - 8*i -: 8];
    end
    @(negedge clk);
    valid = 1; sof = 0; data = 8'h00;
    chk("latency R8 not yet", 32'(done), 0);
    @(negedge clk);
    valid = 0;
    chk("latency R8 ready", 32'(done), 1);
    chk("latency R5 hit", 32'(miss), 0);
    prom = 1; bdis = 1; aind = 1; hash = '1; sta = ~sta;
    repeat (4) @(negedge clk);
    chk("hold R8 done", 32'(done), 1);
    chk("hold R8 miss", 32'(miss), 0);
    chk("hold R8 accept", 32'(acc), 1);
    valid = 1; sof = 1; data = 8'h77;
    @(negedge clk);
    valid = 0; sof = 0;
    chk("sof clear R8 done", 32'(done), 0);
    chk("sof clear R1 accept", 32'(acc), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog R8 actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule